// File: doc/BRIEF.md
# Space-Vector PWM Modulator

This block turns a reference line-voltage vector into a three-leg switching pattern for a two-level, three-phase bridge. The reference comes in as a magnitude and an angle. Once per sampling period the block samples the reference and finds which of the six 60-degree sectors holds it. It then works out how many clock cycles to spend on each of the two active vectors that bound that sector, and gives the rest of the period to a null vector. It plays these out as a 3-bit leg state, where a 1 on a leg means its top switch is on.

The sampling period is set in clock cycles. Each period is marked with a one-cycle strobe, and the current sector number is shown beside the leg state. A reference sampled at one strobe is played in the period that follows it, so a controller gets a full period to prepare the next reference. The trigonometry uses a sine table computed when the design is built. Reference magnitudes above unity are clamped. The controller is expected to step the angle so that every sector is visited equally, which means the number of periods per fundamental cycle should be a multiple of six.

Top module: `svpwm_mod`

## Requirements
- R1: During and after reset, and until the first period begins, `leg_abc` is 000, `sector` is 0 and `period_stb` is low. No period begins before a `start` pulse.
- R2: After `start`, the block runs back-to-back periods of L clock cycles each. `period_stb` is high in exactly the first cycle of every period.
- R3: The block latches `ref_mag`, `ref_ang` and `period_len` on the rising edge where `start` is accepted in the idle state, and on every rising edge that closes a cycle with `period_stb` high. The values latched at one such edge govern the next period that begins. A `start` pulse while periods are running has no effect.
- R4: With `ref_ang` in the range 0 to 383 (sector span 64 steps), the sector is s = floor(ref_ang/64)+1 and the in-sector angle is θ = ref_ang mod 64. `sector` shows s from the first cycle of the period and holds it for the whole period.
- R5: Within a period the leg state is V_s for T1 cycles, then V_(s mod 6 + 1) for T2 cycles, then the null vector for T0 cycles. The codes (a,b,c) are V1=100, V2=110, V3=010, V4=011, V5=001, V6=101. Any phase of zero length is skipped.
- R6: With unity magnitude equal to 256 and q(i) = round(4096·sin(i·π/192)) for i = 0..64, the dwell times are T1 = floor(L·m·q(64−θ)/2^20), T2 = floor(L·m·q(θ)/2^20) and T0 = L − T1 − T2.
- R7: A `ref_mag` above 256 is used as 256. A magnitude of 0 gives a whole period of the null vector.
- R8: The null vector is 111 (all top switches on) in the first period after `start`. It then alternates between 000 and 111 from one period to the next.
- R9: The period length is L = max(`period_len`, 8). A requested length below 8 cycles is raised to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts periodic operation |
| ref_mag | input | MAG_W | Reference magnitude, unity = 2^MAG_F |
| ref_ang | input | TH_W+3 | Reference angle, 2^TH_W steps per sector, six sectors |
| period_len | input | CNT_W | Requested sampling period in clock cycles |
| leg_abc | output | 3 | Leg states a,b,c; 1 = top switch on |
| sector | output | 3 | Sector 1..6 of the playing period, 0 when idle |
| period_stb | output | 1 | High in the first cycle of each period |

## Verification
The assertions assume that `ref_ang` never reaches 384 and that the reference and period length hold steady across each latching edge. Under those assumptions they can rely on a valid sector on every strobe and on at least eight cycles between strobes. The stimulus only draws angles from 0 to 383. It changes the reference only in the cycle right after a latching edge, so the value in place at each strobe is always the one queued for the next period. Period lengths below the minimum and magnitudes above unity are sent on purpose, because the block itself maps them into range.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_RUN
  } sq_state_e;

  localparam logic [2:0] NULL_TOP = 3'b111;
  localparam logic [2:0] NULL_BOT = 3'b000;

  // Active vector leg code for sector index 0..5 (vectors 1..6, counter-clockwise)
  function automatic logic [2:0] active_code(input logic [2:0] idx);
    case (idx)
      3'd0:    return 3'b100;
      3'd1:    return 3'b110;
      3'd2:    return 3'b010;
      3'd3:    return 3'b011;
      3'd4:    return 3'b001;
      default: return 3'b101;
    endcase
  endfunction

  function automatic logic [2:0] next_sector(input logic [2:0] idx);
    return (idx == 3'd5) ? 3'd0 : idx + 3'd1;
  endfunction

endpackage

// File: rtl/svpwm_sin_rom.sv
module svpwm_sin_rom #(
  parameter int TH_W  = 6,
  parameter int SIN_W = 12
) (
  input  logic             clk,
  input  logic [TH_W:0]    addr_a,
  input  logic [TH_W:0]    addr_b,
  output logic [SIN_W-1:0] data_a,
  output logic [SIN_W-1:0] data_b
);
  localparam int  N_ENT = (1 << TH_W) + 1;
  localparam real PI_C  = 3.14159265358979323846;

  logic [SIN_W-1:0] tab [N_ENT];

  // Sine over one sector (0..60 degrees), built at elaboration
  for (genvar i = 0; i < N_ENT; i++) begin : g_tab
    localparam real ARG = PI_C / 3.0 * real'(i) / real'(1 << TH_W);
    localparam int  VAL = $rtoi($sin(ARG) * real'(1 << SIN_W) + 0.5);
    assign tab[i] = SIN_W'(VAL);
  end

  // Registered reads, two ports
  always_ff @(posedge clk) begin
    data_a <= tab[addr_a];
    data_b <= tab[addr_b];
  end
endmodule

// File: rtl/svpwm_dwell.sv
module svpwm_dwell #(
  parameter int MAG_W = 10,
  parameter int MAG_F = 8,
  parameter int TH_W  = 6,
  parameter int SIN_W = 12,
  parameter int CNT_W = 12,
  parameter int MIN_T = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [MAG_W-1:0] mag_i,
  input  logic [TH_W+2:0]  ang_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             vld_o,
  output logic [CNT_W-1:0] t1_o,
  output logic [CNT_W-1:0] t12_o,
  output logic [CNT_W-1:0] len_o,
  output logic [2:0]       sec_o
);
  localparam int MW   = MAG_F + 1;
  localparam int ONE  = 1 << MAG_F;
  localparam int PW   = CNT_W + MW + SIN_W;
  localparam int SH   = MAG_F + SIN_W;
  localparam int PRW  = MW + SIN_W;

  // stage 0: latch, clamp, split angle
  logic             v0;
  logic [MW-1:0]    m0;
  logic [TH_W-1:0]  th0;
  logic [2:0]       sec0;
  logic [CNT_W-1:0] len0;

  always_ff @(posedge clk) begin
    if (rst) v0 <= 1'b0;
    else     v0 <= cap;
    if (cap) begin
      m0   <= (mag_i > MAG_W'(ONE)) ? MW'(ONE) : mag_i[MW-1:0];
      th0  <= ang_i[TH_W-1:0];
      sec0 <= ang_i[TH_W+2:TH_W];
      len0 <= (len_i < CNT_W'(MIN_T)) ? CNT_W'(MIN_T) : len_i;
    end
  end

  // stage 1: table lookup
  logic [TH_W:0]    addr_a, addr_b;
  logic [SIN_W-1:0] sin_a, sin_b;

  assign addr_a = (TH_W+1)'(1 << TH_W) - {1'b0, th0};
  assign addr_b = {1'b0, th0};

  svpwm_sin_rom #(.TH_W(TH_W), .SIN_W(SIN_W)) u_rom (
    .clk    (clk),
    .addr_a (addr_a),
    .addr_b (addr_b),
    .data_a (sin_a),
    .data_b (sin_b)
  );

  logic             v1;
  logic [MW-1:0]    m1;
  logic [2:0]       sec1;
  logic [CNT_W-1:0] len1;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= v0;
    m1   <= m0;
    sec1 <= sec0;
    len1 <= len0;
  end

  // stage 2: magnitude times sine
  logic             v2;
  logic [PRW-1:0]   p1, p2;
  logic [2:0]       sec2;
  logic [CNT_W-1:0] len2;

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v1;
    p1   <= PRW'(m1) * PRW'(sin_a);
    p2   <= PRW'(m1) * PRW'(sin_b);
    sec2 <= sec1;
    len2 <= len1;
  end

  // stage 3: scale by period, floor to whole cycles
  logic [PW-1:0]    full1, full2;
  logic             v3;
  logic [CNT_W-1:0] t1_3, t2_3;
  logic [2:0]       sec3;
  logic [CNT_W-1:0] len3;

  assign full1 = PW'(len2) * PW'(p1);
  assign full2 = PW'(len2) * PW'(p2);

  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else     v3 <= v2;
    t1_3 <= CNT_W'(full1 >> SH);
    t2_3 <= CNT_W'(full2 >> SH);
    sec3 <= sec2;
    len3 <= len2;
  end

  // stage 4: boundary of second active phase
  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= v3;
    t1_o  <= t1_3;
    t12_o <= t1_3 + t2_3;
    len_o <= len3;
    sec_o <= sec3;
  end
endmodule

// File: rtl/svpwm_seq.sv
module svpwm_seq
  import svpwm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             nx_vld,
  input  logic [CNT_W-1:0] nx_t1,
  input  logic [CNT_W-1:0] nx_t12,
  input  logic [CNT_W-1:0] nx_len,
  input  logic [2:0]       nx_sec,
  output logic             cap_o,
  output logic [2:0]       leg_o,
  output logic [2:0]       sec_o,
  output logic             stb_o
);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  sq_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_t1, cur_t12, cur_len;
  logic [2:0]       cur_sec;
  logic [2:0]       cur_null;
  logic             top_next;
  logic             nb_ok;
  logic [CNT_W-1:0] nb_t1, nb_t12, nb_len;
  logic [2:0]       nb_sec;
  logic             at_end;

  function automatic logic [2:0] leg_at(input logic [CNT_W-1:0] n,
                                        input logic [CNT_W-1:0] t1,
                                        input logic [CNT_W-1:0] t12,
                                        input logic [2:0]       sec,
                                        input logic [2:0]       nul);
    if (n < t1)       return active_code(sec);
    else if (n < t12) return active_code(next_sector(sec));
    else              return nul;
  endfunction

  assign cap_o  = ((state == SQ_IDLE) && start) || stb_o;
  assign at_end = (cnt == cur_len - ONE_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_IDLE;
      cnt      <= '0;
      leg_o    <= NULL_BOT;
      sec_o    <= 3'd0;
      stb_o    <= 1'b0;
      top_next <= 1'b1;
      nb_ok    <= 1'b0;
      cur_t1   <= '0;
      cur_t12  <= '0;
      cur_len  <= '0;
      cur_sec  <= 3'd0;
      cur_null <= NULL_BOT;
    end else begin
      if (nx_vld) begin
        nb_ok  <= 1'b1;
        nb_t1  <= nx_t1;
        nb_t12 <= nx_t12;
        nb_len <= nx_len;
        nb_sec <= nx_sec;
      end
      if ((state == SQ_WAIT && nb_ok) || (state == SQ_RUN && at_end)) begin
        state    <= SQ_RUN;
        cnt      <= '0;
        cur_t1   <= nb_t1;
        cur_t12  <= nb_t12;
        cur_len  <= nb_len;
        cur_sec  <= nb_sec;
        cur_null <= top_next ? NULL_TOP : NULL_BOT;
        top_next <= ~top_next;
        nb_ok    <= 1'b0;
        leg_o    <= leg_at('0, nb_t1, nb_t12, nb_sec, top_next ? NULL_TOP : NULL_BOT);
        sec_o    <= nb_sec + 3'd1;
        stb_o    <= 1'b1;
      end else if (state == SQ_RUN) begin
        cnt   <= cnt + ONE_C;
        leg_o <= leg_at(cnt + ONE_C, cur_t1, cur_t12, cur_sec, cur_null);
        stb_o <= 1'b0;
      end else if (state == SQ_IDLE && start) begin
        state <= SQ_WAIT;
      end
    end
  end
endmodule

// File: rtl/svpwm_mod.sv
module svpwm_mod #(
  parameter int MAG_W = 10,
  parameter int MAG_F = 8,
  parameter int TH_W  = 6,
  parameter int SIN_W = 12,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [MAG_W-1:0] ref_mag,
  input  logic [TH_W+2:0]  ref_ang,
  input  logic [CNT_W-1:0] period_len,
  output logic [2:0]       leg_abc,
  output logic [2:0]       sector,
  output logic             period_stb
);
  localparam int PIPE_D = 5;
  localparam int MIN_T  = PIPE_D + 3;

  logic             cap;
  logic             nx_vld;
  logic [CNT_W-1:0] nx_t1, nx_t12, nx_len;
  logic [2:0]       nx_sec;

  svpwm_dwell #(
    .MAG_W (MAG_W), .MAG_F (MAG_F), .TH_W (TH_W),
    .SIN_W (SIN_W), .CNT_W (CNT_W), .MIN_T (MIN_T)
  ) u_dwell (
    .clk   (clk),
    .rst   (rst),
    .cap   (cap),
    .mag_i (ref_mag),
    .ang_i (ref_ang),
    .len_i (period_len),
    .vld_o (nx_vld),
    .t1_o  (nx_t1),
    .t12_o (nx_t12),
    .len_o (nx_len),
    .sec_o (nx_sec)
  );

  svpwm_seq #(.CNT_W(CNT_W)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .nx_vld (nx_vld),
    .nx_t1  (nx_t1),
    .nx_t12 (nx_t12),
    .nx_len (nx_len),
    .nx_sec (nx_sec),
    .cap_o  (cap),
    .leg_o  (leg_abc),
    .sec_o  (sector),
    .stb_o  (period_stb)
  );
endmodule

// File: rtl/svpwm_chk.sv
module svpwm_chk #(
  parameter int MIN_T = 8
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] leg,
  input logic [2:0] sector,
  input logic       stb
);
  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (stb) begin
      gap  <= 16'd1;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 16'd1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sector == 3'd0) |-> (leg == 3'b000 && !stb)); // R1

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stb |=> !stb); // R2

  AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (rst)
    stb |-> (sector >= 3'd1 && sector <= 3'd6)); // R4

  AST_SECTOR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb |-> $stable(sector)); // R4

  AST_NULL_LAST: assert property (@(posedge clk) disable iff (rst)
    (!stb && ($past(leg) == 3'b000 || $past(leg) == 3'b111)) |-> (leg == $past(leg))); // R5

  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (rst)
    (stb && seen) |-> (gap >= 16'(MIN_T))); // R9
endmodule

bind svpwm_mod svpwm_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .leg    (leg_abc),
  .sector (sector),
  .stb    (period_stb)
);

// File: tb/svpwm_mod_tb_top.sv
module svpwm_mod_tb_top;
  localparam int  NV   = 12;
  localparam real PI_C = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [9:0]  ref_mag = '0;
  logic [8:0]  ref_ang = '0;
  logic [11:0] period_len = 12'd40;
  logic [2:0]  leg_abc;
  logic [2:0]  sector;
  logic        period_stb;

  always #5 clk = ~clk;

  svpwm_mod dut_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ref_mag    (ref_mag),
    .ref_ang    (ref_ang),
    .period_len (period_len),
    .leg_abc    (leg_abc),
    .sector     (sector),
    .period_stb (period_stb)
  );

  typedef struct {
    int         len;
    int         t1;
    int         t2;
    int         sec;
    logic [2:0] va;
    logic [2:0] vb;
    logic [2:0] nul;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   top_next = 1'b1;
  bit   mon_on = 1'b0;
  bit   mon_done = 1'b0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sinq(input int i);
    return $rtoi($sin(PI_C / 3.0 * real'(i) / real'(64)) * 4096.0 + 0.5);
  endfunction

  function automatic logic [2:0] code_of(input int idx);
    case (idx)
      0: return 3'b100;
      1: return 3'b110;
      2: return 3'b010;
      3: return 3'b011;
      4: return 3'b001;
      default: return 3'b101;
    endcase
  endfunction

  // Driver: apply a reference and push the period it must produce
  task automatic drive_vec(input int len, input int mag, input int ang, input string tag);
    exp_t e;
    int   lc, mc, s, th;
    lc = (len < 8) ? 8 : len;          // R9
    mc = (mag > 256) ? 256 : mag;      // R7
    s  = ang / 64;                     // R4
    th = ang % 64;
    e.len = lc;
    e.t1  = int'((longint'(lc) * longint'(mc) * longint'(sinq(64 - th))) >>> 20); // R6
    e.t2  = int'((longint'(lc) * longint'(mc) * longint'(sinq(th))) >>> 20);
    e.sec = s + 1;
    e.va  = code_of(s);                // R5
    e.vb  = code_of((s + 1) % 6);
    e.nul = top_next ? 3'b111 : 3'b000; // R8
    top_next = ~top_next;
    e.tag = tag;
    ref_mag    = 10'(mag);
    ref_ang    = 9'(ang);
    period_len = 12'(len);
    q.push_back(e);
  endtask

  // Monitor: compare each played period with the queue head
  exp_t cur;
  bit   have_cur = 1'b0;
  int   idx = 0;
  int   leg_err = 0;
  int   bad_act = 0;
  int   bad_exp = 0;

  always @(negedge clk) begin
    if (mon_on && !mon_done) begin
      if (period_stb) begin
        if (have_cur) begin
          chk(idx == cur.len, "R2 R9", {cur.tag, " period length"}, idx, cur.len);
          chk(leg_err == 0, "R5 R6 R8", {cur.tag, " leg sequence"}, bad_act, bad_exp);
        end
        if (q.size() > 0) begin
          cur      = q.pop_front();
          have_cur = 1'b1;
          idx      = 0;
          leg_err  = 0;
          chk(int'(sector) == cur.sec, "R4", {cur.tag, " sector"}, int'(sector), cur.sec);
        end else begin
          have_cur = 1'b0;
          mon_done = 1'b1;
        end
      end
      if (have_cur && !mon_done) begin
        logic [2:0] ex;
        if (idx < cur.t1)               ex = cur.va;
        else if (idx < cur.t1 + cur.t2) ex = cur.vb;
        else                            ex = cur.nul;
        if (leg_abc !== ex && leg_err == 0) begin
          bad_act = int'(leg_abc);
          bad_exp = int'(ex);
        end
        if (leg_abc !== ex) leg_err++;
        idx++;
      end
    end
  end

  int vlen [NV] = '{40, 40, 60, 50, 3, 64, 80, 45, 100, 8, 70, 33};
  int vmag [NV] = '{256, 0, 600, 128, 200, 256, 180, 256, 90, 256, 255, 300};
  int vang [NV] = '{32, 100, 160, 192, 250, 383, 290, 64, 10, 32, 330, 140};
  string vtag [NV] = '{"R6 mid-sector", "R7 zero magnitude", "R7 clamp",
                       "R4 sector edge", "R9 short period", "R4 last step",
                       "R6 sector5", "R4 sector2 start", "R6 small mag",
                       "R9 minimum period", "R6 sector6", "R7 clamp sector3"};

  initial begin
    int idle_bad;
    repeat (4) @(negedge clk);
    chk(leg_abc == 3'b000 && sector == 3'd0 && !period_stb, "R1", "outputs in reset",
        int'({leg_abc, sector, period_stb}), 0);
    rst = 1'b0;
    idle_bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (leg_abc != 3'b000 || sector != 3'd0 || period_stb) idle_bad++;
    end
    chk(idle_bad == 0, "R1", "idle before start", idle_bad, 0);

    mon_on = 1'b1;
    drive_vec(vlen[0], vmag[0], vang[0], {"R3 first ", vtag[0]});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drive_vec(vlen[1], vmag[1], vang[1], vtag[1]);
    for (int k = 2; k < NV; k++) begin
      @(negedge clk iff period_stb);
      @(negedge clk);
      drive_vec(vlen[k], vmag[k], vang[k], vtag[k]);
      if (k == 6) begin
        // R3: start while running must not disturb the periods
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    wait (mon_done);
    chk(q.size() == 0, "R3", "all queued periods played", q.size(), 0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule